// File: doc/BRIEF.md
# Co-processor Clock Generator

This block produces the clock for a power-management co-processor. One of four incoming parent clocks is picked by a glitch-free multiplexer. The picked clock is then divided by a power of two (1, 2, 4 or 8) and after that by an integer from 1 to 32. A single 32-bit control word holds the settings. It is written over a simple write strobe and can be read back.

Software writes the source, prescale and divide fields in one write. The multiplexer hands over between parents with a handshake: the old parent is turned off in its own domain before the new one is turned on in its own domain. The divider loads a new ratio only when the current output period ends. The output therefore never shows a shortened pulse. The overall ratio is `(divide field + 1) << prescale field`. When that ratio is 1, the selected parent passes through unchanged.

Top module: `copro_clkgen`

## Requirements
- R1: While reset is asserted and after it is released, the control word reads 0, and `clk_out` follows parent 0 undivided (same period, high for half a parent period).
- R2: A write stores bits 17:16 (source), 12:8 (divide field M) and 5:4 (prescale field P). A read returns those bits as written. Every other bit reads 0 and ignores writes. For example, writing 0xFFFFFFFF reads back 0x00031F30.
- R3: Source value s (0 to 3) routes `src_clk[s]` to the divider.
- R4: The prescale field P divides the selected parent by 2^P.
- R5: The output period is R parent periods, where R = (M+1) << P. R ranges from 1 to 256.
- R6: For R ≥ 2 the output is high for ceil(R/2) parent periods, starting at the rising edge that begins each period. This gives 50% duty for even R. For R = 1 the output is the parent clock itself.
- R7: A source change produces no pulse, high or low, shorter than half a period of the faster of the two parents. At most one parent is enabled at any time.
- R8: A new ratio takes effect only at the end of a full output period of the old ratio. While the ratio changes, no high or low phase is shorter than the shorter phase of either ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word (unused bits zero) |
| src_clk | input | 4 | The four parent clocks, index = source value |
| clk_out | output | 1 | Generated co-processor clock |

## Verification
The embedded properties check four things on every edge of their domain: the control word is zero under reset, it reads back masked after each write, the parent enables stay mutually exclusive, and the divider's counter stays below the active ratio and reloads that ratio only when the count wraps to zero. Other behaviours show up only in the directed scenarios, by timing `clk_out` edges: which parent is routed, the exact period and high time for each prescale and divide setting, the pass-through case, and the absence of runt pulses across a ratio change and across handovers between parents of different speeds.

// File: rtl/copro_clkgen_pkg.sv
`timescale 1ns/1ps
package copro_clkgen_pkg;
  localparam int REG_W   = 32;
  localparam int SEL_LSB = 16;
  localparam int SEL_W   = 2;
  localparam int DIV_LSB = 8;
  localparam int DIV_W   = 5;
  localparam int PRE_LSB = 4;
  localparam int PRE_W   = 2;
  localparam int NUM_SRC = 1 << SEL_W;
  // widest ratio: 2^DIV_W shifted by (2^PRE_W - 1)
  localparam int RAT_W   = DIV_W + (1 << PRE_W);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] dvd;
    logic [PRE_W-1:0] pre;
  } ctl_t;
endpackage

// File: rtl/copro_rst_sync.sv
`timescale 1ns/1ps
module copro_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/copro_ctl_reg.sv
`timescale 1ns/1ps
module copro_ctl_reg
  import copro_clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output ctl_t               ctl,
  output logic [NUM_SRC-1:0] sel_oh
);
  localparam logic [REG_W-1:0] FIELD_MASK =
      ((REG_W'(1) << SEL_W) - 1) << SEL_LSB |
      ((REG_W'(1) << DIV_W) - 1) << DIV_LSB |
      ((REG_W'(1) << PRE_W) - 1) << PRE_LSB;

  ctl_t               ctl_q, ctl_d;
  logic [NUM_SRC-1:0] oh_q, oh_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.sel = wr_data[SEL_LSB +: SEL_W];
      ctl_d.dvd = wr_data[DIV_LSB +: DIV_W];
      ctl_d.pre = wr_data[PRE_LSB +: PRE_W];
    end
    oh_d = NUM_SRC'(1) << ctl_q.sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      oh_q  <= NUM_SRC'(1);
    end else begin
      ctl_q <= ctl_d;
      oh_q  <= oh_d;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[SEL_LSB +: SEL_W] = ctl_q.sel;
    rd_data[DIV_LSB +: DIV_W] = ctl_q.dvd;
    rd_data[PRE_LSB +: PRE_W] = ctl_q.pre;
  end

  assign ctl    = ctl_q;
  assign sel_oh = oh_q;

  // R1: control word is zero while the domain is held in reset
  always @(posedge clk) begin
    if (!rst_n) p_reset_zero_r1: assert (rd_data == '0);
  end

  // R2: read-back equals the written word restricted to the three fields
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == ($past(wr_data) & FIELD_MASK)));
endmodule

// File: rtl/copro_clk_mux.sv
`timescale 1ns/1ps
module copro_clk_mux
  import copro_clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [NUM_SRC-1:0] src_rst_n,
  input  logic [NUM_SRC-1:0] sel_oh,
  output logic               gclk
);
  logic [NUM_SRC-1:0] en_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
    localparam logic [NUM_SRC-1:0] OTHERS = ~(NUM_SRC'(1) << i);
    logic req;
    logic meta_q;
    logic en_leg_q;

    // ask for this leg only once every other leg is off
    always_comb req = sel_oh[i] & ~|(en_q & OTHERS);

    always_ff @(posedge src_clk[i] or negedge src_rst_n[i]) begin
      if (!src_rst_n[i]) meta_q <= 1'b0;
      else               meta_q <= req;
    end

    // second stage on the falling edge: enable moves while the clock is low
    always_ff @(negedge src_clk[i] or negedge src_rst_n[i]) begin
      if (!src_rst_n[i]) en_leg_q <= 1'b0;
      else               en_leg_q <= meta_q;
    end

    assign en_q[i] = en_leg_q;
  end

  assign gclk = |(src_clk & en_q);

  // R7: never two parents gated through at once
  p_onehot_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_q));
endmodule

// File: rtl/copro_ratio_div.sv
`timescale 1ns/1ps
module copro_ratio_div
  import copro_clkgen_pkg::*;
(
  input  logic             gclk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] dvd,
  input  logic [PRE_W-1:0] pre,
  output logic             clk_out
);
  localparam int CW = DIV_W + PRE_W;

  logic [CW-1:0]    cfg_m_q, cfg_s_q;
  logic [RAT_W-1:0] cfg_ratio;
  logic [RAT_W-1:0] cnt_q, cnt_d;
  logic [RAT_W-1:0] act_q, act_d;
  logic             out_q, out_d;
  logic             byp_q, byp_d;
  logic [RAT_W-1:0] hi_len;
  logic [RAT_W-1:0] cnt_inc;
  logic             last;

  // two-flop capture of the quasi-static settings
  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_m_q <= '0;
      cfg_s_q <= '0;
    end else begin
      cfg_m_q <= {dvd, pre};
      cfg_s_q <= cfg_m_q;
    end
  end

  always_comb begin
    cfg_ratio = (RAT_W'(cfg_s_q[CW-1:PRE_W]) + RAT_W'(1)) << cfg_s_q[PRE_W-1:0];
    hi_len    = (act_q + RAT_W'(1)) >> 1;
    cnt_inc   = cnt_q + RAT_W'(1);
    last      = (cnt_q == act_q - RAT_W'(1));
    if (last) begin
      cnt_d = '0;
      act_d = cfg_ratio;
      byp_d = (cfg_ratio == RAT_W'(1));
      out_d = 1'b1;
    end else begin
      cnt_d = cnt_inc;
      act_d = act_q;
      byp_d = byp_q;
      out_d = (cnt_inc < hi_len);
    end
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= RAT_W'(1);
      byp_q <= 1'b1;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      byp_q <= byp_d;
      out_q <= out_d;
    end
  end

  assign clk_out = byp_q ? gclk : out_q;

  // R5: position inside the period never reaches the active ratio
  p_cnt_bound_r5: assert property (@(posedge gclk) disable iff (!rst_n)
    cnt_q < act_q);

  // R8: the active ratio only changes as a new period starts
  p_load_at_wrap_r8: assert property (@(posedge gclk) disable iff (!rst_n)
    !$stable(act_q) |-> (cnt_q == '0));
endmodule

// File: rtl/copro_clkgen.sv
`timescale 1ns/1ps
module copro_clkgen
  import copro_clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic [NUM_SRC-1:0] src_clk,
  output logic               clk_out
);
  logic               reg_rst_n;
  logic               div_rst_n;
  logic [NUM_SRC-1:0] src_rst_n;
  logic [NUM_SRC-1:0] sel_oh;
  logic               gclk;
  ctl_t               ctl;

  copro_rst_sync u_rs_reg (.clk(clk), .arst_n(rst_n), .srst_n(reg_rst_n));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_rst
    copro_rst_sync u_rs (.clk(src_clk[i]), .arst_n(rst_n), .srst_n(src_rst_n[i]));
  end

  copro_rst_sync u_rs_div (.clk(gclk), .arst_n(rst_n), .srst_n(div_rst_n));

  copro_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (reg_rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .ctl     (ctl),
    .sel_oh  (sel_oh)
  );

  copro_clk_mux u_mux (
    .clk       (clk),
    .rst_n     (reg_rst_n),
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .sel_oh    (sel_oh),
    .gclk      (gclk)
  );

  copro_ratio_div u_div (
    .gclk    (gclk),
    .rst_n   (div_rst_n),
    .dvd     (ctl.dvd),
    .pre     (ctl.pre),
    .clk_out (clk_out)
  );
endmodule

// File: tb/copro_clkgen_tb.sv
`timescale 1ns/1ps
module copro_clkgen_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  src;
  logic        clk_out;

  int  n_chk;
  int  n_bad;
  real t_src [4];
  real cur_per;

  real last_rise, last_fall, min_hi, min_lo;
  bit  have_rise, have_fall;

  copro_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_clk(src), .clk_out(clk_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  initial src = 4'b0000;
  always #5  src[0] = ~src[0];
  always #8  src[1] = ~src[1];
  always #3  src[2] = ~src[2];
  always #10 src[3] = ~src[3];

  always @(posedge clk_out) begin
    if (have_fall && ($realtime - last_fall) < min_lo) min_lo = $realtime - last_fall;
    last_rise = $realtime;
    have_rise = 1'b1;
  end
  always @(negedge clk_out) begin
    if (have_rise && ($realtime - last_rise) < min_hi) min_hi = $realtime - last_rise;
    last_fall = $realtime;
    have_fall = 1'b1;
  end

  task automatic clear_mins();
    have_rise = 1'b0;
    have_fall = 1'b0;
    min_hi = 1.0e9;
    min_lo = 1.0e9;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [31:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s read-back: actual %08h expected %08h", req, rd_data, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
    @(negedge clk);
  endtask

  function automatic real ratio_of(input int pre, input int dv);
    return real'((dv + 1) << pre);
  endfunction

  function automatic real hi_of(input real r, input real t);
    if (r == 1.0) return t / 2.0;
    return real'((int'(r) + 1) / 2) * t;
  endfunction

  task automatic set_cfg(input int sel, input int pre, input int dv);
    real old;
    old = cur_per;
    write_word((32'(sel) << 16) | (32'(dv) << 8) | (32'(pre) << 4));
    cur_per = ratio_of(pre, dv) * t_src[sel];
    #(old + 4.0 * cur_per + 300.0);
  endtask

  task automatic measure(input string req, input real per, input real hi);
    real t0, t1, t2;
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    chk(((t2 - t0) - per) < 0.01 && ((t2 - t0) - per) > -0.01, req, "period", t2 - t0, per);
    chk(((t1 - t0) - hi) < 0.01 && ((t1 - t0) - hi) > -0.01, req, "high time", t1 - t0, hi);
  endtask

  task automatic run_cfg(input string req, input int sel, input int pre, input int dv);
    real r;
    set_cfg(sel, pre, dv);
    r = ratio_of(pre, dv);
    measure(req, r * t_src[sel], hi_of(r, t_src[sel]));
  endtask

  // R1: reset state
  task automatic t_reset();
    chk_word("R1", 32'h0);
    measure("R1", 10.0, 5.0);
  endtask

  // R2: field storage and masking, then the same word used as a setting (R4, R5)
  task automatic t_regs();
    write_word(32'hFFFF_FFFF);
    chk_word("R2", 32'h0003_1F30);
    write_word(32'hA5A5_A5A5);
    chk_word("R2", 32'h0001_0520);
    cur_per = 10.0;
    cur_per = 24.0 * 16.0;
    #(4.0 * cur_per + 300.0);
    measure("R5", 384.0, 192.0);
  endtask

  // R3: each parent routed with a ratio of 2
  task automatic t_sources();
    for (int s = 0; s < 4; s++) run_cfg("R3", s, 0, 1);
  endtask

  // R4: prescale alone on parent 2, includes the R=1 pass-through of R6
  task automatic t_prescale();
    for (int p = 0; p < 4; p++) run_cfg("R4", 2, p, 0);
  endtask

  // R5 and R6: integer divider, odd and even ratios, the largest ratio
  task automatic t_divider();
    run_cfg("R5", 2, 0, 31);
    run_cfg("R6", 2, 0, 4);
    run_cfg("R6", 2, 1, 6);
    run_cfg("R5", 2, 3, 31);
  endtask

  // R8: ratio 8 to ratio 3 on parent 0, no phase shorter than 10 ns
  task automatic t_boundary();
    run_cfg("R8", 0, 3, 0);
    clear_mins();
    run_cfg("R8", 0, 0, 2);
    chk(min_hi > 19.99, "R8", "shortest high", min_hi, 20.0);
    chk(min_lo > 9.99,  "R8", "shortest low",  min_lo, 10.0);
  endtask

  // R7: pass-through handovers 10 ns -> 6 ns -> 20 ns parents
  task automatic t_switch();
    run_cfg("R7", 0, 0, 0);
    clear_mins();
    run_cfg("R7", 2, 0, 0);
    run_cfg("R7", 3, 0, 0);
    chk(min_hi > 2.99, "R7", "shortest high", min_hi, 3.0);
    chk(min_lo > 2.99, "R7", "shortest low",  min_lo, 3.0);
  endtask

  initial begin
    #700000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_src[0] = 10.0; t_src[1] = 16.0; t_src[2] = 6.0; t_src[3] = 20.0;
    n_chk = 0;
    n_bad = 0;
    cur_per = 10.0;
    clear_mins();
    wr_en   = 1'b0;
    wr_data = '0;
    rst_n   = 1'b1;
    #1 rst_n = 1'b0;
    #40;
    chk_word("R1", 32'h0);
    #60 rst_n = 1'b1;
    #200;
    t_reset();
    t_regs();
    t_sources();
    t_prescale();
    t_divider();
    t_boundary();
    t_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule